// File: doc/BRIEF.md
# USB Full-Speed Frame Interval Timer

This block sets the frame rhythm of a full-speed USB host controller. A 14-bit counter runs down once per bit time. When it has run out, the next bit time loads it again from a programmable frame interval and raises a one-cycle start-of-frame strobe. The same event loads a per-frame packet-budget counter from a programmable 15-bit value. That counter then runs down with the bit clock and stops at zero. The packet scheduler uses it to decide whether a transaction still fits in the frame.

Software reaches the block through one command port. A command code picks the register and the access: read codes have bit 7 clear and write codes have bit 7 set. Software may load a new interval while a frame is running. The new value only takes effect at the next reload, and a toggle bit that software writes is copied into the frame-remaining register at that reload. A host-controller reset input puts the interval back to its nominal value of 11999 bit times.

Top module: `usb_frame_timer`

## Requirements
- R1: After the asynchronous reset the interval field is 11999, the frame-remaining count is 11999, both toggle bits are 0, the budget value and budget counter are 0, `ldp_zero_o` is 1 and `sof_o` is 0.
- R2: Write code 8Dh stores the interval register. Bit 31 is the interval toggle, bits 30:16 are the budget value and bits 13:0 are the interval. Read code 0Dh returns the register, with bits 15:14 read as 0.
- R3: Read code 0Eh returns the frame-remaining register: bit 31 is the frame toggle, bits 13:0 are the count and bits 30:14 are 0. Write code 8Eh loads the count from bits 13:0 and leaves the toggle unchanged. In a cycle where this write and a bit-time enable arrive together, the write wins.
- R4: On each `bit_en_i` pulse a nonzero count falls by one. Without an enable the count holds.
- R5: An enable with the count at 0 reloads the count from the interval and drives `sof_o` high for exactly that one cycle after the edge. Consecutive SOFs are interval+1 enables apart.
- R6: An interval written during a frame does not change that frame. It is used only from the next reload on.
- R7: At each reload the frame toggle takes the value of the interval toggle.
- R8: At each reload the budget counter loads the budget value. Each other enable lowers it by one, it stays at 0 once it gets there, and `ldp_zero_o` is 1 exactly when it is 0.
- R9: A cycle with `hc_reset_i` high sets the interval field to 11999. This overrides a write to 8Dh in the same cycle, but the toggle and budget fields of that write are still stored.
- R10: Any other command code reads as 0 and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hc_reset_i | input | 1 | Host-controller reset, restores the nominal interval |
| bit_en_i | input | 1 | One pulse per full-speed bit time |
| cmd_vld_i | input | 1 | Command strobe |
| cmd_i | input | 8 | Command code |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the current read code, combinational |
| sof_o | output | 1 | Start-of-frame pulse |
| ldp_cnt_o | output | 15 | Packet-budget counter |
| ldp_zero_o | output | 1 | Budget counter is zero |

## Verification
The checker assumes that `bit_en_i` and the command strobe are synchronous single-cycle levels sampled at the rising clock edge. It also assumes that `hc_reset_i` is synchronous and not tied to the asynchronous reset. Under these assumptions every counter step, reload and SOF can be traced to the enable of the previous cycle. The stimulus drives all inputs one time unit after a rising edge and reads the combinational register port before the next edge, so no access straddles a clock edge. Frame intervals are set to a few bit times so that several reloads, toggle transfers and budget saturations occur in a short run. The nominal 11999 interval is exercised once, after the host-controller reset.

// File: rtl/ft_pkg.sv
package ft_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned CNT_W    = 14;
  localparam int unsigned LDP_W    = 15;
  localparam int unsigned LDP_LSB  = 16;
  localparam int unsigned TOG_BIT  = 31;
  localparam logic [CNT_W-1:0] FI_NOMINAL = 14'd11999;

  localparam logic [7:0] CMD_FI_RD  = 8'h0D;
  localparam logic [7:0] CMD_FI_WR  = 8'h8D;
  localparam logic [7:0] CMD_REM_RD = 8'h0E;
  localparam logic [7:0] CMD_REM_WR = 8'h8E;
endpackage

// File: rtl/ft_regs.sv
module ft_regs
  import ft_pkg::*;
#(
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned CW     = CNT_W,
  parameter int unsigned LW     = LDP_W,
  parameter logic [CW-1:0] FI_RST = FI_NOMINAL
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hc_reset_i,
  input  logic          cmd_vld_i,
  input  logic [7:0]    cmd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [CW-1:0] rem_i,
  input  logic          rem_tog_i,
  output logic [CW-1:0] fi_o,
  output logic [LW-1:0] fsmps_o,
  output logic          fit_o,
  output logic          rem_wr_o,
  output logic [CW-1:0] rem_wdata_o,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned LDP_MSB = LDP_LSB + LW - 1;

  logic fi_wr;

  assign fi_wr       = cmd_vld_i && (cmd_i == CMD_FI_WR);
  assign rem_wr_o    = cmd_vld_i && (cmd_i == CMD_REM_WR);
  assign rem_wdata_o = wdata_i[CW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fi_o    <= FI_RST;
      fsmps_o <= '0;
      fit_o   <= 1'b0;
    end else begin
      if (fi_wr) begin
        fsmps_o <= wdata_i[LDP_MSB:LDP_LSB];
        fit_o   <= wdata_i[TOG_BIT];
      end
      // host-controller reset outranks software on the interval field only
      if (hc_reset_i)  fi_o <= FI_RST;
      else if (fi_wr)  fi_o <= wdata_i[CW-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (cmd_vld_i) begin
      unique case (cmd_i)
        CMD_FI_RD: begin
          rdata_o[CW-1:0]          = fi_o;
          rdata_o[LDP_MSB:LDP_LSB] = fsmps_o;
          rdata_o[TOG_BIT]         = fit_o;
        end
        CMD_REM_RD: begin
          rdata_o[CW-1:0]  = rem_i;
          rdata_o[TOG_BIT] = rem_tog_i;
        end
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/ft_frame_cnt.sv
module ft_frame_cnt
  import ft_pkg::*;
#(
  parameter int unsigned CW     = CNT_W,
  parameter logic [CW-1:0] FI_RST = FI_NOMINAL
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_en_i,
  input  logic          wr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic [CW-1:0] fi_i,
  input  logic          fit_i,
  output logic [CW-1:0] rem_o,
  output logic          tog_o,
  output logic          reload_o,
  output logic          sof_o
);
  assign reload_o = bit_en_i && !wr_i && (rem_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_o <= FI_RST;
      tog_o <= 1'b0;
      sof_o <= 1'b0;
    end else begin
      sof_o <= reload_o;
      if (wr_i) begin
        rem_o <= wdata_i;
      end else if (reload_o) begin
        rem_o <= fi_i;
        tog_o <= fit_i;
      end else if (bit_en_i) begin
        rem_o <= rem_o - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ft_budget_cnt.sv
module ft_budget_cnt
  import ft_pkg::*;
#(
  parameter int unsigned LW = LDP_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_en_i,
  input  logic          load_i,
  input  logic [LW-1:0] init_i,
  output logic [LW-1:0] cnt_o,
  output logic          zero_o
);
  assign zero_o = (cnt_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_o <= '0;
    else if (load_i)             cnt_o <= init_i;
    else if (bit_en_i && !zero_o) cnt_o <= cnt_o - 1'b1;
  end
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
  import ft_pkg::*;
#(
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned CW     = CNT_W,
  parameter int unsigned LW     = LDP_W,
  parameter logic [CW-1:0] FI_RST = FI_NOMINAL
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hc_reset_i,
  input  logic          bit_en_i,
  input  logic          cmd_vld_i,
  input  logic [7:0]    cmd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          sof_o,
  output logic [LW-1:0] ldp_cnt_o,
  output logic          ldp_zero_o
);
  logic [CW-1:0] fi_q;
  logic [LW-1:0] fsmps_q;
  logic          fit_q;
  logic [CW-1:0] rem_q;
  logic          rem_tog_q;
  logic          rem_wr;
  logic [CW-1:0] rem_wdata;
  logic          reload;

  ft_regs #(.DW(DW), .CW(CW), .LW(LW), .FI_RST(FI_RST)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hc_reset_i (hc_reset_i),
    .cmd_vld_i  (cmd_vld_i),
    .cmd_i      (cmd_i),
    .wdata_i    (wdata_i),
    .rem_i      (rem_q),
    .rem_tog_i  (rem_tog_q),
    .fi_o       (fi_q),
    .fsmps_o    (fsmps_q),
    .fit_o      (fit_q),
    .rem_wr_o   (rem_wr),
    .rem_wdata_o(rem_wdata),
    .rdata_o    (rdata_o)
  );

  ft_frame_cnt #(.CW(CW), .FI_RST(FI_RST)) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bit_en_i(bit_en_i),
    .wr_i    (rem_wr),
    .wdata_i (rem_wdata),
    .fi_i    (fi_q),
    .fit_i   (fit_q),
    .rem_o   (rem_q),
    .tog_o   (rem_tog_q),
    .reload_o(reload),
    .sof_o   (sof_o)
  );

  ft_budget_cnt #(.LW(LW)) u_budget (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bit_en_i(bit_en_i),
    .load_i  (reload),
    .init_i  (fsmps_q),
    .cnt_o   (ldp_cnt_o),
    .zero_o  (ldp_zero_o)
  );
endmodule

// File: rtl/usb_frame_timer_chk.sv
module usb_frame_timer_chk
  import ft_pkg::*;
#(
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned CW     = CNT_W,
  parameter int unsigned LW     = LDP_W,
  parameter logic [CW-1:0] FI_RST = FI_NOMINAL
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hc_reset_i,
  input logic          bit_en_i,
  input logic          cmd_vld_i,
  input logic [7:0]    cmd_i,
  input logic [DW-1:0] rdata_o,
  input logic          sof_o,
  input logic [LW-1:0] ldp_cnt_o,
  input logic          ldp_zero_o,
  input logic [CW-1:0] fi_q,
  input logic          fit_q,
  input logic [LW-1:0] fsmps_q,
  input logic [CW-1:0] rem_q,
  input logic          rem_tog_q,
  input logic          rem_wr
);
  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_i && cmd_i == CMD_FI_RD) |-> rdata_o[15:14] == 2'b00);

  p_rem_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_en_i && !rem_wr) |=> $stable(rem_q));

  p_rem_dec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && !rem_wr && rem_q != '0) |=> rem_q == $past(rem_q) - 1'b1);

  p_sof_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> ($past(bit_en_i) && $past(rem_q) == '0 && !$past(rem_wr)));

  p_sof_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> rem_q == $past(fi_q));

  p_tog_copy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> rem_tog_q == $past(fit_q));

  p_budget_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> ldp_cnt_o == $past(fsmps_q));

  p_budget_sat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ldp_zero_o && !(bit_en_i && !rem_wr && rem_q == '0)) |=> ldp_cnt_o == '0);

  p_zero_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ldp_zero_o == (ldp_cnt_o == '0));

  p_hc_nominal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hc_reset_i |=> fi_q == FI_RST);
endmodule

bind usb_frame_timer usb_frame_timer_chk #(
  .DW(DW), .CW(CW), .LW(LW), .FI_RST(FI_RST)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .hc_reset_i(hc_reset_i),
  .bit_en_i  (bit_en_i),
  .cmd_vld_i (cmd_vld_i),
  .cmd_i     (cmd_i),
  .rdata_o   (rdata_o),
  .sof_o     (sof_o),
  .ldp_cnt_o (ldp_cnt_o),
  .ldp_zero_o(ldp_zero_o),
  .fi_q      (fi_q),
  .fit_q     (fit_q),
  .fsmps_q   (fsmps_q),
  .rem_q     (rem_q),
  .rem_tog_q (rem_tog_q),
  .rem_wr    (rem_wr)
);

// File: tb/tb_usb_frame_timer.sv
module tb_usb_frame_timer;
  localparam time CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0]  wcmd;
    logic [31:0] wdat;
    logic [7:0]  rcmd;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'h8D, 32'hFFFF_FFFF, 8'h0D, 32'hFFFF_3FFF},
    '{8'h8D, 32'h0003_0004, 8'h0D, 32'h0003_0004},
    '{8'h8E, 32'hFFFF_FFFF, 8'h0E, 32'h0000_3FFF},
    '{8'h42, 32'h1234_5678, 8'h0D, 32'h0003_0004},
    '{8'h8E, 32'h0000_0007, 8'h0D, 32'h0003_0004},
    '{8'h8E, 32'h0000_0002, 8'h0E, 32'h0000_0002}
  };
  localparam string TAGS [NV] = '{"R2", "R2", "R3", "R10", "R3", "R3"};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hc_reset_i = 1'b0;
  logic        bit_en_i = 1'b0;
  logic        cmd_vld_i = 1'b0;
  logic [7:0]  cmd_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        sof_o;
  logic [14:0] ldp_cnt_o;
  logic        ldp_zero_o;

  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  usb_frame_timer dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .hc_reset_i(hc_reset_i), .bit_en_i(bit_en_i),
    .cmd_vld_i(cmd_vld_i), .cmd_i(cmd_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .sof_o(sof_o), .ldp_cnt_o(ldp_cnt_o), .ldp_zero_o(ldp_zero_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic en);
    bit_en_i = en;
    @(posedge clk_i);
    #1;
    bit_en_i = 1'b0;
  endtask

  task automatic wr(input logic [7:0] c, input logic [31:0] d);
    cmd_vld_i = 1'b1; cmd_i = c; wdata_i = d;
    @(posedge clk_i);
    #1;
    cmd_vld_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] c, output logic [31:0] d);
    cmd_vld_i = 1'b1; cmd_i = c;
    #1;
    d = rdata_o;
    cmd_vld_i = 1'b0;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset state
    rd(8'h0D, r); check("R1 interval", r, 32'h0000_2EDF);
    rd(8'h0E, r); check("R1 remaining", r, 32'h0000_2EDF);
    check("R1 budget", {17'b0, ldp_cnt_o}, 32'h0);
    check("R1 zero flag", {31'b0, ldp_zero_o}, 32'h1);
    check("R1 sof", {31'b0, sof_o}, 32'h0);

    // register vector table
    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].wcmd, VECS[i].wdat);
      rd(VECS[i].rcmd, r);
      check(TAGS[i], r, VECS[i].exp);
    end
    rd(8'h0F, r); check("R10 unknown read", r, 32'h0);

    // interval 4, budget 3, count 2
    cyc(0); cyc(0); cyc(0);
    rd(8'h0E, r); check("R4 hold", r, 32'h2);
    cyc(1); rd(8'h0E, r); check("R4 dec", r, 32'h1);
    cyc(1); check("R5 no sof before wrap", {31'b0, sof_o}, 32'h0);
    cyc(1); check("R5 sof", {31'b0, sof_o}, 32'h1);
    rd(8'h0E, r); check("R5 reload", r, 32'h4);
    check("R8 budget load", {17'b0, ldp_cnt_o}, 32'h3);
    cyc(1); check("R5 sof one cycle", {31'b0, sof_o}, 32'h0);
    check("R8 budget dec", {17'b0, ldp_cnt_o}, 32'h2);
    cyc(1); cyc(1);
    check("R8 budget zero", {17'b0, ldp_cnt_o}, 32'h0);
    check("R8 zero flag", {31'b0, ldp_zero_o}, 32'h1);
    cyc(1);
    check("R8 saturate", {17'b0, ldp_cnt_o}, 32'h0);
    check("R5 no early sof", {31'b0, sof_o}, 32'h0);
    cyc(1); check("R5 spacing interval+1", {31'b0, sof_o}, 32'h1);

    // R6/R7 reprogram mid-frame: toggle 1, budget 2, interval 1
    wr(8'h8D, 32'h8002_0001);
    rd(8'h0E, r); check("R6 frame unchanged", r, 32'h4);
    repeat (4) cyc(1);
    rd(8'h0E, r); check("R6 old length", r, 32'h0);
    cyc(1); check("R6 sof old frame end", {31'b0, sof_o}, 32'h1);
    rd(8'h0E, r); check("R7 toggle copied", r, 32'h8000_0001);
    check("R8 new budget", {17'b0, ldp_cnt_o}, 32'h2);
    cyc(1); check("R6 mid new frame", {31'b0, sof_o}, 32'h0);
    cyc(1); check("R6 new length", {31'b0, sof_o}, 32'h1);

    // R3 write beats enable in the same cycle
    bit_en_i = 1'b1;
    wr(8'h8E, 32'h0000_0009);
    bit_en_i = 1'b0;
    rd(8'h0E, r); check("R3 write priority", r, 32'h8000_0009);

    // R9 host-controller reset
    hc_reset_i = 1'b1;
    wr(8'h8D, 32'h0001_0005);
    hc_reset_i = 1'b0;
    rd(8'h0D, r); check("R9 override write", r, 32'h0001_2EDF);
    wr(8'h8D, 32'h0001_0003);
    hc_reset_i = 1'b1; cyc(0); hc_reset_i = 1'b0;
    rd(8'h0D, r); check("R9 restore", r, 32'h0001_2EDF);
    repeat (10) cyc(1);
    check("R9 sof", {31'b0, sof_o}, 32'h1);
    rd(8'h0E, r); check("R9 nominal reload", r, 32'h0000_2EDF);

    // R1 asynchronous reset mid-run
    rst_ni = 1'b0;
    #2;
    rd(8'h0D, r); check("R1 async interval", r, 32'h0000_2EDF);
    rd(8'h0E, r); check("R1 async remaining", r, 32'h0000_2EDF);
    check("R1 async budget", {17'b0, ldp_cnt_o}, 32'h0);
    @(posedge clk_i); #1 rst_ni = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule